// File: doc/BRIEF.md
# Cascadable Single-Port Block RAM

This block is a synchronous single-port memory with a parameterized word width and depth. One clock edge performs either a write or a read at the presented address. The result appears on the read-data output after one clock, or after two when an extra output pipeline stage is enabled by parameter.

Each instance compares a 3-bit select input against its own fixed 3-bit match parameter and responds only when the two are equal. Up to eight instances can therefore share address, data and control lines and act together as one deeper memory, with the select input carrying the upper address bits.

A write-behaviour parameter sets what the read-data output shows on a write cycle: the last read value (keep), the word being written (pass-through), or the word previously stored at that address (old-data). A reset-style parameter makes the clearing of the output registers either asynchronous or clocked.

Top module: `cascade_bram`

## Requirements
- R1: When selected with clock enable high and write enable low, the word stored at `addr` appears on `rdata` one clock later with `PIPE=PIPE_OFF`, or two clocks later with `PIPE=PIPE_ON`. A read that follows a write to the same address returns the new word.
- R2: With `WMODE=WR_KEEP`, a selected write leaves the first read-data stage unchanged.
- R3: With `WMODE=WR_THRU`, a selected write loads the word being written into the first read-data stage.
- R4: With `WMODE=WR_OLD`, a selected write loads the word previously held at the written address into the first read-data stage, and the new word is stored.
- R5: `WMODE=WR_OLD` is accepted only for `WIDTH` of 9, 18 or 36. Any other width is refused at elaboration. The package function `old_mode_width_ok` states this rule.
- R6: The block is selected only when `ce` is high and `cs` equals `CS_MATCH`. If `cs` differs, a write changes no stored word and the first read-data stage holds its value.
- R7: While `ce` is low, nothing is written and both read-data stages hold their values.
- R8: With `PIPE=PIPE_ON`, `rdata` is the first-stage value delayed by one enabled clock.
- R9: Reset (`rst_n` low) clears the read-data registers to zero. With `RMODE=RST_ASYNC` this happens at once; with `RMODE=RST_SYNC` it happens at the next rising clock edge. Stored words survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the read-data registers |
| ce | input | 1 | Clock enable |
| cs | input | 3 | Cascade select, compared with `CS_MATCH` |
| we | input | 1 | Write enable (1 = write, 0 = read) |
| addr | input | $clog2(DEPTH) | Word address |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data |

## Verification
The bench builds three instances that share one stimulus stream, all at width 18, depth 64 and match code 3'b101. The first uses old-data writes, the output pipeline and asynchronous reset. The second uses pass-through writes, no pipeline and clocked reset. The third uses keep writes, the pipeline and clocked reset. Running the same sequence through all three lets the bench compare the three write behaviours and the one- and two-clock latencies cycle by cycle. Dropping reset in the middle of the run shows that the asynchronous instance clears before the clock edge and the clocked ones clear at it, while reads afterwards show that the stored words are intact.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [1:0] {WR_KEEP, WR_THRU, WR_OLD} wr_mode_e;
  typedef enum logic {PIPE_OFF, PIPE_ON} pipe_mode_e;
  typedef enum logic {RST_SYNC, RST_ASYNC} rst_mode_e;

  // R5: old-data write behaviour is limited to these word widths
  function automatic bit old_mode_width_ok(int unsigned w);
    return (w == 9) || (w == 18) || (w == 36);
  endfunction
endpackage

// File: rtl/cbr_select.sv
module cbr_select #(
  parameter logic [2:0] CS_MATCH = 3'b000
) (
  input  logic       ce,
  input  logic [2:0] cs,
  output logic       hit
);
  // R6: respond only to this instance's cascade code
  always_comb begin
    hit = ce && (cs == CS_MATCH);
  end
endmodule

// File: rtl/cbr_store.sv
module cbr_store
  import cbr_pkg::*;
#(
  parameter int unsigned WIDTH = 18,
  parameter int unsigned DEPTH = 64,
  parameter wr_mode_e    WMODE = WR_KEEP,
  parameter rst_mode_e   RMODE = RST_ASYNC,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] q_nxt;

  always_ff @(posedge clk) begin
    if (hit && we) begin
      mem[addr] <= wdata;
    end
  end

  always_comb begin
    q_nxt = q;
    if (hit) begin
      if (!we) begin
        q_nxt = mem[addr];
      end else if (WMODE == WR_THRU) begin
        q_nxt = wdata;
      end else if (WMODE == WR_OLD) begin
        q_nxt = mem[addr];
      end
    end
  end

  generate
    if (RMODE == RST_ASYNC) begin : g_arst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
      end
    end else begin : g_srst
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
      end
    end
  endgenerate

  // R6 / R7: an unselected or disabled cycle leaves the first stage alone
  p_unsel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(q));

  generate
    if (WMODE == WR_KEEP) begin : g_chk_keep
      p_keep_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && we) |=> $stable(q));
    end else if (WMODE == WR_THRU) begin : g_chk_thru
      p_thru_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && we) |=> (q == $past(wdata)));
    end
  endgenerate
endmodule

// File: rtl/cbr_outpipe.sv
module cbr_outpipe
  import cbr_pkg::*;
#(
  parameter int unsigned WIDTH = 18,
  parameter pipe_mode_e  PIPE  = PIPE_ON,
  parameter rst_mode_e   RMODE = RST_ASYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (PIPE == PIPE_OFF) begin : g_bypass
      logic unused_pipe_in;
      assign unused_pipe_in = ^{clk, rst_n, ce};
      assign q = d;
    end else begin : g_stage
      logic [WIDTH-1:0] q_r;
      logic [WIDTH-1:0] q_nxt;

      always_comb begin
        q_nxt = q_r;
        if (ce) q_nxt = d;
      end

      if (RMODE == RST_ASYNC) begin : g_arst
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q_r <= '0;
          else        q_r <= q_nxt;
        end
        p_rst_clear_r9: assert property (@(posedge clk)
          !rst_n |-> (q_r == '0));
      end else begin : g_srst
        always_ff @(posedge clk) begin
          if (!rst_n) q_r <= '0;
          else        q_r <= q_nxt;
        end
        p_rst_clear_r9: assert property (@(posedge clk)
          !rst_n |=> (q_r == '0));
      end

      assign q = q_r;
    end
  endgenerate
endmodule

// File: rtl/cascade_bram.sv
module cascade_bram
  import cbr_pkg::*;
#(
  parameter int unsigned WIDTH    = 18,
  parameter int unsigned DEPTH    = 64,
  parameter logic [2:0]  CS_MATCH = 3'b101,
  parameter wr_mode_e    WMODE    = WR_OLD,
  parameter pipe_mode_e  PIPE     = PIPE_ON,
  parameter rst_mode_e   RMODE    = RST_ASYNC,
  localparam int unsigned AW      = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [2:0]       cs,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  // R5: refuse an old-data build at an unsupported width
  generate
    if (WMODE == WR_OLD && !old_mode_width_ok(WIDTH)) begin : g_bad_width
      $error("cascade_bram: old-data write mode needs WIDTH 9, 18 or 36");
    end
  endgenerate

  logic             hit;
  logic [WIDTH-1:0] stage1;

  cbr_select #(.CS_MATCH(CS_MATCH)) u_sel (
    .ce  (ce),
    .cs  (cs),
    .hit (hit)
  );

  cbr_store #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .WMODE(WMODE), .RMODE(RMODE)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .we    (we),
    .addr  (addr),
    .wdata (wdata),
    .q     (stage1)
  );

  cbr_outpipe #(.WIDTH(WIDTH), .PIPE(PIPE), .RMODE(RMODE)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce),
    .d     (stage1),
    .q     (rdata)
  );

  // R1: a read right after a write to the same address returns the new word
  p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !we && $past(hit && we) && (addr == $past(addr)))
      |=> (stage1 == $past(wdata, 2)));
endmodule

// File: tb/cascade_bram_tb_top.sv
`timescale 1ns/100ps
module cascade_bram_tb_top;
  import cbr_pkg::*;

  localparam int unsigned W = 18;
  localparam int unsigned D = 64;
  localparam int unsigned AW = $clog2(D);
  localparam logic [2:0] MATCH = 3'b101;

  logic clk = 1'b0;
  logic rst_n;
  logic ce;
  logic [2:0] cs;
  logic we;
  logic [AW-1:0] addr;
  logic [W-1:0] wdata;
  logic [W-1:0] rd_a, rd_b, rd_c;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  cascade_bram #(.WIDTH(W), .DEPTH(D), .CS_MATCH(MATCH), .WMODE(WR_OLD),
                 .PIPE(PIPE_ON), .RMODE(RST_ASYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rd_a));

  cascade_bram #(.WIDTH(W), .DEPTH(D), .CS_MATCH(MATCH), .WMODE(WR_THRU),
                 .PIPE(PIPE_OFF), .RMODE(RST_SYNC)) dut_thru_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rd_b));

  cascade_bram #(.WIDTH(W), .DEPTH(D), .CS_MATCH(MATCH), .WMODE(WR_KEEP),
                 .PIPE(PIPE_ON), .RMODE(RST_SYNC)) dut_keep_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rd_c));

  typedef struct {
    logic [W-1:0] ea, eb, ec;
    bit va, vb, vc;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  // reference model state
  logic [W-1:0] mem_m [D];
  bit           mem_v [D];
  logic [W-1:0] s1a, s2a, s1b, s1c, s2c;
  bit           v1a, v2a, v1b, v1c, v2c;

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    s1a = '0; s2a = '0; s1b = '0; s1c = '0; s2c = '0;
    v1a = 1; v2a = 1; v1b = 1; v1c = 1; v2c = 1;
  endtask

  // driver: apply one cycle of stimulus and push what each output must show
  task automatic step(bit c, logic [2:0] s, bit w, int a, logic [W-1:0] d, string tag);
    logic [W-1:0] n1a, n1b, n1c;
    bit nv1a, nv1b, nv1c;
    exp_t e;
    @(negedge clk);
    ce = c; cs = s; we = w; addr = AW'(a); wdata = d;
    n1a = s1a; n1b = s1b; n1c = s1c;
    nv1a = v1a; nv1b = v1b; nv1c = v1c;
    if (c && s == MATCH) begin
      if (w) begin
        n1a = mem_m[a]; nv1a = mem_v[a];
        n1b = d; nv1b = 1;
        mem_m[a] = d; mem_v[a] = 1;
      end else begin
        n1a = mem_m[a]; nv1a = mem_v[a];
        n1b = mem_m[a]; nv1b = mem_v[a];
        n1c = mem_m[a]; nv1c = mem_v[a];
      end
    end
    if (c) begin
      s2a = s1a; v2a = v1a;
      s2c = s1c; v2c = v1c;
    end
    s1a = n1a; v1a = nv1a;
    s1b = n1b; v1b = nv1b;
    s1c = n1c; v1c = nv1c;
    e.ea = s2a; e.eb = s1b; e.ec = s2c;
    e.va = v2a; e.vb = v1b; e.vc = v2c;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compare outputs one time unit after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.va) chk(e.tag, "old-data/pipelined", rd_a, e.ea);
        if (e.vb) chk(e.tag, "pass-through/direct", rd_b, e.eb);
        if (e.vc) chk(e.tag, "keep/pipelined", rd_c, e.ec);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce = 1'b0; cs = '0; we = 1'b0; addr = '0; wdata = '0;
    for (int i = 0; i < D; i++) begin mem_m[i] = '0; mem_v[i] = 0; end
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state of every output
    chk("R9", "reset a", rd_a, '0);
    chk("R9", "reset b", rd_b, '0);
    chk("R9", "reset c", rd_c, '0);

    // R5: width rule for old-data mode
    checks++;
    if (old_mode_width_ok(16) || !old_mode_width_ok(18) || !old_mode_width_ok(9)
        || !old_mode_width_ok(36) || old_mode_width_ok(32)) begin
      fails++;
      $display("FAIL R5: actual width rule wrong expected 9/18/36 only");
    end

    // fill: R3 pass-through and R2 keep visible, R4 old contents unknown
    for (int i = 0; i < 8; i++) step(1, MATCH, 1, i, W'(18'h0A000 + i * 18'h111), "R3");
    // R1: plain reads, one and two clock latency
    for (int i = 0; i < 8; i++) step(1, MATCH, 0, i, '0, "R1");
    // R4 / R3 / R2: overwrite with known old contents
    step(1, MATCH, 1, 2, 18'h3F0F0, "R4");
    step(1, MATCH, 1, 3, 18'h05A5A, "R4");
    step(1, MATCH, 1, 6, 18'h12345, "R2");
    // R1: read back straight after write
    step(1, MATCH, 1, 9, 18'h2BEEF, "R1");
    step(1, MATCH, 0, 9, '0, "R1");
    step(1, MATCH, 0, 2, '0, "R1");
    step(1, MATCH, 0, 3, '0, "R1");
    // R6: wrong cascade code, write ignored and outputs hold
    step(1, 3'b100, 1, 4, 18'h3FFFF, "R6");
    step(1, 3'b001, 0, 5, '0, "R6");
    step(1, MATCH, 0, 4, '0, "R6");
    step(1, MATCH, 0, 0, '0, "R6");
    // R7: clock enable low, write ignored and both stages hold
    step(0, MATCH, 1, 5, 18'h00001, "R7");
    step(0, MATCH, 0, 1, '0, "R7");
    step(1, MATCH, 0, 5, '0, "R7");
    step(1, MATCH, 0, 5, '0, "R7");
    // R8: alternating reads show the extra stage
    step(1, MATCH, 0, 1, '0, "R8");
    step(1, MATCH, 0, 6, '0, "R8");
    step(1, MATCH, 0, 7, '0, "R8");
    step(1, MATCH, 0, 7, '0, "R8");
    step(0, MATCH, 0, 0, '0, "R8");

    // R9: reset in mid-run
    @(negedge clk);
    ce = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R9", "async clear a", rd_a, '0);
    chk("R9", "sync hold b", rd_b, s1b);
    chk("R9", "sync hold c", rd_c, s2c);
    @(posedge clk);
    #1;
    chk("R9", "sync clear b", rd_b, '0);
    chk("R9", "sync clear c", rd_c, '0);
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    // R9: stored words survive reset
    step(1, MATCH, 0, 7, '0, "R9");
    step(1, MATCH, 0, 2, '0, "R9");
    step(1, MATCH, 0, 2, '0, "R9");
    step(0, MATCH, 0, 0, '0, "R9");
    repeat (3) @(posedge clk);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule